// File: doc/BRIEF.md
# Burst Splitting Adapter

This block sits between one memory-mapped host port and one agent port. The agent cannot take bursts longer than a fixed number of beats. A host burst can run from 1 to 256 beats and is one of three kinds: incrementing, wrapping or fixed. The adapter takes that burst and issues it to the agent as a series of commands, each of which the agent can legally accept. Write beats and read beats pass through one at a time. Both directions are throttled by valid/ready handshakes. Only one agent command is in flight at any time.

From the moment it accepts a host burst until the last beat of that burst completes, the adapter raises a lock output. An external arbiter uses that signal to keep the agent's grant with this host. The maximum agent burst, the beat width in bytes and the address width are all fixed at elaboration. Alignment is measured against the agent burst boundary, which spans MAX_LEN beats. If a burst starts off that boundary, the first command carries only enough beats to reach it, and its first beat carries a partial byte mask. Every later command then starts on the boundary.

Top module: `burst_split_adapter`

## Requirements
- R1: Every agent command has a length from 1 to MAX_LEN (default 4). An incrementing host burst of N aligned beats becomes ceil(N/MAX_LEN) commands, so 16 beats from address 0 become four 4-beat commands.
- R2: For incrementing bursts, each command after the first starts at the beat-aligned start address of the previous command plus that command's beat count times BYTES (default 4).
- R3: `lock` rises in the cycle after a host command is accepted and stays high until the last beat completes. While it is high, `h_cmd_ready` is 0. When the adapter is idle, `lock` is 0 and `h_cmd_ready` is 1.
- R4: A fixed burst (`h_btype`=2) of N beats becomes N single-beat commands, all at the host's start address, with `a_wrap`=0.
- R5: A wrapping burst (`h_btype`=1) whose length is at most MAX_LEN is issued as one command with `a_wrap`=1. That command carries the host address and the host length.
- R6: A wrapping burst longer than MAX_LEN is issued as incrementing commands (`a_wrap`=0) that follow the wrapped address sequence. The wrap window is length×BYTES bytes and is aligned to its own size. For example, 8 beats at 0x18 become (0x18,2), (0x00,4) and (0x10,2).
- R7: Take the beat offset as (address/BYTES) mod MAX_LEN. If the start beat offset is not zero, the first command has length min(N, MAX_LEN−offset). Bit i of `a_be` marks byte lane i of the command's first beat. On the first command, `a_be` has bits below address mod BYTES cleared. On every later command, `a_be` is all ones and the address is aligned. For example, 6 beats at 0x0A become (0x0A,2,`a_be`=1100b) and then (0x10,4,1111b).
- R8: A 256-beat incrementing burst is accepted and completes as 64 commands of 4 beats each. The last of these starts at 0x3F0 when the burst starts at 0.
- R9: For reads, a new agent command is issued only after every beat of the previous one has returned. The host receives exactly N beats, in order, and `h_rlast` is set only on the final beat.
- R10: Write beats pass to the agent in order with their data unchanged. `a_wlast` marks the last beat of each agent command, once per command.
- R11: A reset (`rst_n` low at a clock edge) in the middle of a burst clears `lock` and returns the adapter to idle, with `h_cmd_ready` 1 and `a_cmd_valid` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| h_cmd_valid | input | 1 | Host burst request |
| h_cmd_ready | output | 1 | Adapter accepts a host burst |
| h_addr | input | ADDR_W | Host start byte address |
| h_len | input | 9 | Host burst length, 1 to 256 |
| h_btype | input | 2 | 0 incrementing, 1 wrapping, 2 fixed |
| h_write | input | 1 | 1 write, 0 read |
| h_wvalid | input | 1 | Host write beat valid |
| h_wready | output | 1 | Write beat taken |
| h_wdata | input | 8*BYTES | Host write data |
| h_rvalid | output | 1 | Read beat to host valid |
| h_rready | input | 1 | Host can take a read beat |
| h_rdata | output | 8*BYTES | Read data to host |
| h_rlast | output | 1 | Final read beat of the host burst |
| lock | output | 1 | Hold the arbiter grant |
| a_cmd_valid | output | 1 | Agent command valid |
| a_cmd_ready | input | 1 | Agent accepts the command |
| a_addr | output | ADDR_W | Agent command start address |
| a_len | output | $clog2(MAX_LEN+1) | Agent command length in beats |
| a_wrap | output | 1 | Agent command is a wrapping burst |
| a_write | output | 1 | Agent command direction |
| a_be | output | BYTES | Byte lanes enabled on the command's first beat |
| a_wvalid | output | 1 | Agent write beat valid |
| a_wready | input | 1 | Agent takes a write beat |
| a_wdata | output | 8*BYTES | Agent write data |
| a_wlast | output | 1 | Last write beat of the agent command |
| a_rvalid | input | 1 | Agent read beat valid |
| a_rready | output | 1 | Adapter takes an agent read beat |
| a_rdata | input | 8*BYTES | Agent read data |

## Verification
The wrapping split at 0x18 checks whether the second command folds back to the window base. A design that skipped the wrap would emit 0x20 there and read outside the window. The unaligned write at 0x0A checks the first command's length and byte mask. If the offset were ignored, the first command would cross the boundary; if the address were not realigned, 0x12 would leak into the second command. The 256-beat write and the fixed burst exercise the remaining-count arithmetic and the frozen address. A stalled read that is reset partway through checks that no lock or command survives the reset.

// File: rtl/bsa_pkg.sv
// Shared types for the burst splitting adapter.
package bsa_pkg;
    typedef enum logic [1:0] {
        BT_INCR  = 2'd0,
        BT_WRAP  = 2'd1,
        BT_FIXED = 2'd2
    } btype_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CMD  = 2'd1,
        ST_DATA = 2'd2
    } state_e;
endpackage

// File: rtl/bsa_plan.sv
// Sub-burst planner: from the current address and the remaining beat count,
// works out the next agent command's length, byte mask and the address after it.
// Assumes MAX_LEN is a power of two and that wrapping lengths are powers of two.
module bsa_plan #(
    parameter int ADDR_W  = 16,
    parameter int BYTES   = 4,
    parameter int MAX_LEN = 4,
    parameter int HLEN_W  = 9,
    parameter int ALEN_W  = 3
) (
    input  logic [ADDR_W-1:0]  cur_addr,
    input  logic [HLEN_W-1:0]  rem,
    input  logic [HLEN_W-1:0]  total,
    input  bsa_pkg::btype_e    btype,
    input  logic               first,
    output logic [ALEN_W-1:0]  chunk_len,
    output logic [ADDR_W-1:0]  next_addr,
    output logic               wrap_cmd,
    output logic [BYTES-1:0]   be
);
    localparam int SHIFT = $clog2(BYTES);

    logic [ADDR_W-1:0] aligned, beat_off, win_mask, next_lin;
    logic [HLEN_W-1:0] room, step;
    logic [BYTES-1:0]  ones;
    int unsigned       byte_off;

    // Boundary arithmetic shared by all burst kinds.
    always_comb begin
        aligned  = cur_addr & ~ADDR_W'(BYTES - 1);
        beat_off = (cur_addr >> SHIFT) & ADDR_W'(MAX_LEN - 1);
        room     = HLEN_W'(MAX_LEN) - HLEN_W'(beat_off);
        step     = (rem < room) ? rem : room;
        win_mask = (ADDR_W'(total) * ADDR_W'(BYTES)) - ADDR_W'(1);
        next_lin = aligned + ADDR_W'(step) * ADDR_W'(BYTES);
        byte_off = 32'(cur_addr & ADDR_W'(BYTES - 1));
        ones     = '1;
        be       = first ? BYTES'(ones << byte_off) : ones;
    end

    // Choose length, next address and command kind per burst type.
    always_comb begin
        chunk_len = ALEN_W'(step);
        next_addr = next_lin;
        wrap_cmd  = 1'b0;
        unique case (btype)
            bsa_pkg::BT_FIXED: begin
                chunk_len = ALEN_W'(1);
                next_addr = cur_addr;
            end
            bsa_pkg::BT_WRAP: begin
                if (first && (total <= HLEN_W'(MAX_LEN))) begin
                    chunk_len = ALEN_W'(total);
                    next_addr = cur_addr;
                    wrap_cmd  = 1'b1;
                end else begin
                    next_addr = (aligned & ~win_mask) | (next_lin & win_mask);
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/bsa_beat.sv
// Beat path: counts the beats of the active agent command, forwards write and
// read beats with their handshakes, and marks command and burst ends.
// Assumes load only happens while no data phase is active.
module bsa_beat #(
    parameter int DATA_W = 32,
    parameter int ALEN_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ALEN_W-1:0] load_len,
    input  logic              active,
    input  logic              is_write,
    input  logic              rem_zero,
    input  logic              h_wvalid,
    input  logic [DATA_W-1:0] h_wdata,
    output logic              h_wready,
    output logic              a_wvalid,
    output logic [DATA_W-1:0] a_wdata,
    output logic              a_wlast,
    input  logic              a_wready,
    input  logic              a_rvalid,
    input  logic [DATA_W-1:0] a_rdata,
    output logic              a_rready,
    output logic              h_rvalid,
    output logic [DATA_W-1:0] h_rdata,
    output logic              h_rlast,
    input  logic              h_rready,
    output logic              sub_done
);
    logic [ALEN_W-1:0] cnt;
    logic              beat, last_beat;

    // Handshake forwarding and end-of-command detection.
    always_comb begin
        a_wvalid  = active && is_write && h_wvalid;
        h_wready  = active && is_write && a_wready;
        a_wdata   = h_wdata;
        h_rvalid  = active && !is_write && a_rvalid;
        a_rready  = active && !is_write && h_rready;
        h_rdata   = a_rdata;
        beat      = is_write ? (a_wvalid && a_wready) : (h_rvalid && h_rready);
        last_beat = (cnt == ALEN_W'(1));
        a_wlast   = a_wvalid && last_beat;
        h_rlast   = h_rvalid && last_beat && rem_zero;
        sub_done  = beat && last_beat;
    end

    // Beats left in the current agent command.
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt <= '0;
        else if (load)  cnt <= load_len;
        else if (beat)  cnt <= cnt - ALEN_W'(1);
    end
endmodule

// File: rtl/burst_split_adapter.sv
// Burst splitting adapter top: accepts one host burst at a time, issues it as
// agent-legal commands one after another, and holds lock for the whole burst.
// Assumes one host burst outstanding and host lengths of 1 to 256.
module burst_split_adapter #(
    parameter int ADDR_W  = 16,
    parameter int BYTES   = 4,
    parameter int MAX_LEN = 4,
    localparam int DATA_W = 8 * BYTES,
    localparam int HLEN_W = 9,
    localparam int ALEN_W = $clog2(MAX_LEN + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              h_cmd_valid,
    output logic              h_cmd_ready,
    input  logic [ADDR_W-1:0] h_addr,
    input  logic [HLEN_W-1:0] h_len,
    input  logic [1:0]        h_btype,
    input  logic              h_write,
    input  logic              h_wvalid,
    output logic              h_wready,
    input  logic [DATA_W-1:0] h_wdata,
    output logic              h_rvalid,
    input  logic              h_rready,
    output logic [DATA_W-1:0] h_rdata,
    output logic              h_rlast,
    output logic              lock,
    output logic              a_cmd_valid,
    input  logic              a_cmd_ready,
    output logic [ADDR_W-1:0] a_addr,
    output logic [ALEN_W-1:0] a_len,
    output logic              a_wrap,
    output logic              a_write,
    output logic [BYTES-1:0]  a_be,
    output logic              a_wvalid,
    input  logic              a_wready,
    output logic [DATA_W-1:0] a_wdata,
    output logic              a_wlast,
    input  logic              a_rvalid,
    output logic              a_rready,
    input  logic [DATA_W-1:0] a_rdata
);
    import bsa_pkg::*;

    state_e            state;
    btype_e            btype_q;
    logic [ADDR_W-1:0] cur_addr, next_addr;
    logic [HLEN_W-1:0] rem, total;
    logic              wr_q, first;
    logic              cmd_fire, sub_done;

    bsa_plan #(
        .ADDR_W(ADDR_W), .BYTES(BYTES), .MAX_LEN(MAX_LEN),
        .HLEN_W(HLEN_W), .ALEN_W(ALEN_W)
    ) u_plan (
        .cur_addr (cur_addr),
        .rem      (rem),
        .total    (total),
        .btype    (btype_q),
        .first    (first),
        .chunk_len(a_len),
        .next_addr(next_addr),
        .wrap_cmd (a_wrap),
        .be       (a_be)
    );

    bsa_beat #(.DATA_W(DATA_W), .ALEN_W(ALEN_W)) u_beat (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (cmd_fire),
        .load_len(a_len),
        .active  (state == ST_DATA),
        .is_write(wr_q),
        .rem_zero(rem == '0),
        .h_wvalid(h_wvalid),
        .h_wdata (h_wdata),
        .h_wready(h_wready),
        .a_wvalid(a_wvalid),
        .a_wdata (a_wdata),
        .a_wlast (a_wlast),
        .a_wready(a_wready),
        .a_rvalid(a_rvalid),
        .a_rdata (a_rdata),
        .a_rready(a_rready),
        .h_rvalid(h_rvalid),
        .h_rdata (h_rdata),
        .h_rlast (h_rlast),
        .h_rready(h_rready),
        .sub_done(sub_done)
    );

    // Port-level decode of the controller state.
    always_comb begin
        h_cmd_ready = (state == ST_IDLE);
        lock        = (state != ST_IDLE);
        a_cmd_valid = (state == ST_CMD);
        a_addr      = cur_addr;
        a_write     = wr_q;
        cmd_fire    = a_cmd_valid && a_cmd_ready;
    end

    // Burst controller: capture, issue each command, wait for its beats.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            btype_q  <= BT_INCR;
            cur_addr <= '0;
            rem      <= '0;
            total    <= '0;
            wr_q     <= 1'b0;
            first    <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (h_cmd_valid) begin
                    state    <= ST_CMD;
                    btype_q  <= btype_e'(h_btype);
                    cur_addr <= h_addr;
                    rem      <= h_len;
                    total    <= h_len;
                    wr_q     <= h_write;
                    first    <= 1'b1;
                end
                ST_CMD: if (cmd_fire) begin
                    state    <= ST_DATA;
                    rem      <= rem - HLEN_W'(a_len);
                    cur_addr <= next_addr;
                    first    <= 1'b0;
                end
                ST_DATA: if (sub_done) begin
                    state <= (rem == '0) ? ST_IDLE : ST_CMD;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/bsa_chk.sv
// Property checker for the burst splitting adapter, attached by bind.
module bsa_chk #(
    parameter int MAX_LEN = 4,
    parameter int ALEN_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              h_cmd_valid,
    input logic              h_cmd_ready,
    input logic              lock,
    input logic              a_cmd_valid,
    input logic              a_cmd_ready,
    input logic [ALEN_W-1:0] a_len,
    input logic              a_wvalid,
    input logic              a_wlast,
    input logic              h_rvalid,
    input logic              h_rlast,
    input logic              a_rready,
    input logic              a_rvalid
);
    AST_CMD_LEN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        a_cmd_valid |-> (a_len >= ALEN_W'(1)) && (a_len <= ALEN_W'(MAX_LEN))); // R1
    AST_LOCK_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (h_cmd_valid && h_cmd_ready) |=> lock); // R3
    AST_NO_ACCEPT_WHILE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        lock |-> !h_cmd_ready); // R3
    AST_RLAST_WITH_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        h_rlast |-> h_rvalid); // R9
    AST_NO_CMD_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
        a_cmd_valid |-> !(a_rready && a_rvalid)); // R9
    AST_WLAST_WITH_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        a_wlast |-> a_wvalid); // R10
    AST_CMD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (a_cmd_valid && !a_cmd_ready) |=> a_cmd_valid); // R1
endmodule

bind burst_split_adapter bsa_chk #(.MAX_LEN(MAX_LEN), .ALEN_W(ALEN_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .h_cmd_valid(h_cmd_valid),
    .h_cmd_ready(h_cmd_ready),
    .lock       (lock),
    .a_cmd_valid(a_cmd_valid),
    .a_cmd_ready(a_cmd_ready),
    .a_len      (a_len),
    .a_wvalid   (a_wvalid),
    .a_wlast    (a_wlast),
    .h_rvalid   (h_rvalid),
    .h_rlast    (h_rlast),
    .a_rready   (a_rready),
    .a_rvalid   (a_rvalid)
);

// File: tb/tb_burst_split_adapter.sv
`timescale 1ns/1ps
module tb_burst_split_adapter;
    localparam int ADDR_W = 16;
    localparam int BYTES  = 4;
    localparam int MAXL   = 4;
    localparam int DW     = 8 * BYTES;
    localparam int ALW    = $clog2(MAXL + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic h_cmd_valid = 1'b0, h_cmd_ready;
    logic [ADDR_W-1:0] h_addr = '0;
    logic [8:0] h_len = 9'd1;
    logic [1:0] h_btype = 2'd0;
    logic h_write = 1'b0;
    logic h_wvalid = 1'b0, h_wready;
    logic [DW-1:0] h_wdata = '0;
    logic h_rvalid, h_rready = 1'b1, h_rlast;
    logic [DW-1:0] h_rdata;
    logic lock;
    logic a_cmd_valid, a_cmd_ready;
    logic [ADDR_W-1:0] a_addr;
    logic [ALW-1:0] a_len;
    logic a_wrap, a_write;
    logic [BYTES-1:0] a_be;
    logic a_wvalid, a_wready, a_wlast;
    logic [DW-1:0] a_wdata;
    logic a_rvalid, a_rready;
    logic [DW-1:0] a_rdata;

    burst_split_adapter #(.ADDR_W(ADDR_W), .BYTES(BYTES), .MAX_LEN(MAXL)) dut (.*);

    always #2 clk = ~clk;   // 250 MHz

    // Agent model: always ready for commands and writes, returns read beats.
    int pend = 0;
    int rd_ctr = 0;
    assign a_cmd_ready = 1'b1;
    assign a_wready    = 1'b1;
    assign a_rvalid    = (pend > 0);
    assign a_rdata     = DW'(rd_ctr);
    always @(posedge clk) begin
        if (!rst_n) pend <= 0;
        else pend <= pend + ((a_cmd_valid && a_cmd_ready && !a_write) ? int'(a_len) : 0)
                          - ((a_rvalid && a_rready) ? 1 : 0);
        if (a_rvalid && a_rready) rd_ctr <= rd_ctr + 1;
    end

    // Monitor: logs commands and beats.
    logic [ADDR_W-1:0] c_addr [0:511];
    int c_len [0:511];
    logic c_wrap [0:511];
    logic [BYTES-1:0] c_be [0:511];
    int ncmd = 0, nrb = 0, nrlast = 0, rlast_idx = -1, rd_err = 0;
    int nwb = 0, nwlast = 0, wd_err = 0, overlap = 0;
    always @(posedge clk) begin
        if (rst_n && a_cmd_valid && a_cmd_ready) begin
            if (ncmd < 512) begin
                c_addr[ncmd] = a_addr; c_len[ncmd] = int'(a_len);
                c_wrap[ncmd] = a_wrap; c_be[ncmd] = a_be;
            end
            if (!a_write && pend != 0) overlap++;
            ncmd++;
        end
        if (h_rvalid && h_rready) begin
            if (h_rdata != DW'(nrb)) rd_err++;
            if (h_rlast) begin nrlast++; rlast_idx = nrb; end
            nrb++;
        end
        if (a_wvalid && a_wready) begin
            if (a_wdata != DW'(nwb)) wd_err++;
            if (a_wlast) nwlast++;
            nwb++;
        end
    end

    int nchk = 0, nerr = 0, hw_sent = 0;
    bit finished = 0;

    task automatic chk(input string tag, input longint act, input longint exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run_burst(input int addr, input int len, input int bt, input bit wr);
        bit rdy;
        @(negedge clk);
        h_addr = ADDR_W'(addr); h_len = 9'(len); h_btype = 2'(bt);
        h_write = wr; h_cmd_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        h_cmd_valid = 1'b0;
        chk("R3 lock after accept", lock, 1);
        chk("R3 no accept while locked", h_cmd_ready, 0);
        for (int g = 0; g < 5000; g++) begin
            if (!lock) break;
            h_wvalid = wr; h_wdata = DW'(hw_sent);
            rdy = h_wready;
            @(posedge clk);
            if (wr && rdy) hw_sent++;
            @(negedge clk);
        end
        h_wvalid = 1'b0;
        chk("R3 lock released", lock, 0);
        chk("R3 idle ready", h_cmd_ready, 1);
    endtask

    task automatic t_reset_state();
        chk("R3 reset lock", lock, 0);
        chk("R3 reset ready", h_cmd_ready, 1);
        chk("R11 reset no cmd", a_cmd_valid, 0);
    endtask

    task automatic t_incr_split();
        int b = ncmd, w0 = nwb, l0 = nwlast;
        run_burst(0, 16, 0, 1);
        chk("R1 16-beat cmd count", ncmd - b, 4);
        for (int i = 0; i < 4; i++) begin
            chk("R1 cmd len", c_len[b+i], 4);
            chk("R2 cmd addr", c_addr[b+i], 16 * i);
        end
        chk("R10 write beats", nwb - w0, 16);
        chk("R10 wlast per cmd", nwlast - l0, 4);
    endtask

    task automatic t_fixed();
        int b = ncmd, r0 = nrb;
        run_burst('h44, 3, 2, 0);
        chk("R4 fixed cmd count", ncmd - b, 3);
        for (int i = 0; i < 3; i++) begin
            chk("R4 fixed addr", c_addr[b+i], 'h44);
            chk("R4 fixed len", c_len[b+i], 1);
            chk("R4 fixed not wrap", c_wrap[b+i], 0);
        end
        chk("R9 fixed read beats", nrb - r0, 3);
    endtask

    task automatic t_wrap_small();
        int b = ncmd;
        run_burst('h38, 4, 1, 0);
        chk("R5 one cmd", ncmd - b, 1);
        chk("R5 addr", c_addr[b], 'h38);
        chk("R5 len", c_len[b], 4);
        chk("R5 wrap flag", c_wrap[b], 1);
    endtask

    task automatic t_wrap_split();
        int b = ncmd;
        run_burst('h18, 8, 1, 0);
        chk("R6 cmd count", ncmd - b, 3);
        chk("R6 addr0", c_addr[b], 'h18);   chk("R6 len0", c_len[b], 2);
        chk("R6 addr1", c_addr[b+1], 'h00); chk("R6 len1", c_len[b+1], 4);
        chk("R6 addr2", c_addr[b+2], 'h10); chk("R6 len2", c_len[b+2], 2);
        chk("R6 incr cmds", c_wrap[b] | c_wrap[b+1] | c_wrap[b+2], 0);
    endtask

    task automatic t_unaligned();
        int b = ncmd, w0 = nwb, l0 = nwlast;
        run_burst('h0A, 6, 0, 1);
        chk("R7 cmd count", ncmd - b, 2);
        chk("R7 first addr", c_addr[b], 'h0A);
        chk("R7 first len", c_len[b], 2);
        chk("R7 first be", c_be[b], 4'b1100);
        chk("R7 second addr", c_addr[b+1], 'h10);
        chk("R7 second len", c_len[b+1], 4);
        chk("R7 second be", c_be[b+1], 4'b1111);
        chk("R10 write beats", nwb - w0, 6);
        chk("R10 wlast count", nwlast - l0, 2);
    endtask

    task automatic t_long();
        int b = ncmd, w0 = nwb, bad = 0;
        run_burst(0, 256, 0, 1);
        chk("R8 cmd count", ncmd - b, 64);
        for (int i = 0; i < 64; i++) if (c_len[b+i] != 4) bad++;
        chk("R8 all len 4", bad, 0);
        chk("R8 last addr", c_addr[b+63], 'h3F0);
        chk("R8 beats", nwb - w0, 256);
    endtask

    task automatic t_read_stream();
        int b = ncmd, r0 = nrb, q0 = nrlast;
        run_burst('h100, 10, 0, 0);
        chk("R2 read cmd count", ncmd - b, 3);
        chk("R2 read addr2", c_addr[b+2], 'h120);
        chk("R9 read beats", nrb - r0, 10);
        chk("R9 single rlast", nrlast - q0, 1);
        chk("R9 rlast on final", rlast_idx, r0 + 9);
        chk("R9 one outstanding", overlap, 0);
        chk("R9 read data order", rd_err, 0);
    endtask

    task automatic t_reset_mid();
        @(negedge clk);
        h_rready = 1'b0;
        h_addr = '0; h_len = 9'd16; h_btype = 2'd0; h_write = 1'b0; h_cmd_valid = 1'b1;
        @(posedge clk); @(negedge clk);
        h_cmd_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk("R11 locked before reset", lock, 1);
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        chk("R11 lock dropped", lock, 0);
        rst_n = 1'b1; h_rready = 1'b1;
        @(negedge clk);
        chk("R11 idle ready", h_cmd_ready, 1);
        chk("R11 no cmd", a_cmd_valid, 0);
        t_wrap_small();
    endtask

    initial begin
        #(4 * 200000);
        if (!finished) begin
            nerr++; nchk++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", nchk, nerr);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_incr_split();
        t_fixed();
        t_wrap_small();
        t_wrap_split();
        t_unaligned();
        t_long();
        t_read_stream();
        t_reset_mid();
        chk("R10 write data order", wd_err, 0);
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end
endmodule